// File: doc/BRIEF.md
# Write Strobe Qualifier

This block sits between the asynchronous control pins of a byte-wide non-volatile memory port and a page-write controller running on a fast system clock. It synchronizes the active-low chip-select, write-enable, output-enable and pin-reset inputs, along with the address and data buses. It finds the window in which both strobes are low, and it turns each valid window into exactly one single-cycle write event. Each event carries an address and a data byte.

The address is taken when the window opens, which happens when the later of the two strobes falls. The data is taken when the window closes, which happens when the earlier of the two strobes rises. A window produces no event if it is too short, if output-enable is low at any point during it, or if the pin reset is low or still inside its protect interval. The event is issued on the clock cycle after the synchronized window closes. The address and data outputs then hold until the next event.

Top module: `wsq_strobe_qual`

## Requirements
- R1: An event (`wr_valid_o` high) is produced only for a window in which `cs_ni` and `we_ni` are both low while `oe_ni` is high; no event occurs without such a window.
- R2: `wr_addr_o` carries the address present on `addr_i` in the first sampled cycle of the window, that is when the later strobe falls; later address changes inside the window are ignored.
- R3: `wr_data_o` carries the data present on `data_i` in the last sampled cycle of the window, that is just before the earlier strobe rises; earlier data values inside the window are ignored.
- R4: If `oe_ni` is low in any sampled cycle of the window, the window produces no event and `wr_addr_o`/`wr_data_o` keep their previous values.
- R5: A window shorter than `MIN_PULSE_CYC` sampled clock cycles produces no event; a window of exactly `MIN_PULSE_CYC` cycles produces one.
- R6: While `prst_ni` is low, no window produces an event.
- R7: After `prst_ni` returns high, and after system reset, windows stay blocked for `PROTECT_CYC` cycles of the synchronized pin reset being high; a window that starts after that interval produces an event.
- R8: Each accepted window gives exactly one `wr_valid_o` pulse one cycle wide. `wr_addr_o` and `wr_data_o` change only together with that pulse.
- R9: After `rst_ni` is asserted, `wr_valid_o` is low and `wr_addr_o`/`wr_data_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| cs_ni | input | 1 | Chip-select pin, active low, asynchronous |
| we_ni | input | 1 | Write-enable pin, active low, asynchronous |
| oe_ni | input | 1 | Output-enable pin, active low; low inhibits writes |
| prst_ni | input | 1 | Pin reset, active low; blocks writes |
| addr_i | input | ADDR_W | Address pins |
| data_i | input | DATA_W | Data pins |
| wr_valid_o | output | 1 | One-cycle write event |
| wr_addr_o | output | ADDR_W | Address of the event |
| wr_data_o | output | DATA_W | Data of the event |

## Verification
The bench drives both strobe orderings, so that either strobe can open or close the window. It changes the address after the window opens and changes the data before the window closes. A design that latched the address late would report the changed address, and one that latched the data early would report the stale data byte. Window widths of one cycle below and exactly at the minimum are applied, which catches an off-by-one in the width filter. Output-enable dips, pin-reset lows and writes issued inside the protect interval are also applied. A design that ignored any of these would issue spurious events or overwrite the held address and data.

// File: rtl/wsq_pkg.sv
package wsq_pkg;
  typedef struct packed {
    logic prst_n;
    logic oe_n;
    logic we_n;
    logic cs_n;
  } pin_ctrl_t;

  localparam pin_ctrl_t CTRL_IDLE = '{prst_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, cs_n: 1'b1};
endpackage

// File: rtl/wsq_sync.sv
module wsq_sync #(
  parameter int unsigned W = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/wsq_protect.sv
module wsq_protect #(
  parameter int unsigned PROTECT_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic prst_n_i,
  output logic blocked_o
);
  localparam int unsigned PROT_W = (PROTECT_CYC < 1) ? 1 : $clog2(PROTECT_CYC + 1);
  localparam logic [PROT_W-1:0] PROT_LOAD = PROT_W'(PROTECT_CYC);

  logic [PROT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= PROT_LOAD;
    end else if (!prst_n_i) begin
      cnt_q <= PROT_LOAD;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign blocked_o = !prst_n_i || (cnt_q != '0);
endmodule

// File: rtl/wsq_window.sv
module wsq_window #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_PULSE_CYC = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              win_i,
  input  logic              oe_hi_i,
  input  logic              blocked_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned CNT_W = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_PULSE_CYC);

  logic              win_q, ok_q, valid_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] addr_q, out_addr_q;
  logic [DATA_W-1:0] data_q, out_data_q;
  logic              start, stop, inhibit;

  assign start   = win_i & ~win_q;
  assign stop    = ~win_i & win_q;
  assign inhibit = ~oe_hi_i | blocked_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= 1'b0;
      ok_q       <= 1'b0;
      valid_q    <= 1'b0;
      cnt_q      <= '0;
      addr_q     <= '0;
      data_q     <= '0;
      out_addr_q <= '0;
      out_data_q <= '0;
    end else begin
      win_q   <= win_i;
      valid_q <= 1'b0;
      if (start) begin
        addr_q <= addr_i;
        data_q <= data_i;
        cnt_q  <= CNT_W'(1);
        ok_q   <= ~inhibit;
      end else if (win_i) begin
        data_q <= data_i;
        if (cnt_q != CNT_MIN) cnt_q <= cnt_q + 1'b1;
        if (inhibit) ok_q <= 1'b0;
      end
      if (stop && ok_q && (cnt_q >= CNT_MIN)) begin
        valid_q    <= 1'b1;
        out_addr_q <= addr_q;
        out_data_q <= data_q;
      end
    end
  end

  assign wr_valid_o = valid_q;
  assign wr_addr_o  = out_addr_q;
  assign wr_data_o  = out_data_q;
endmodule

// File: rtl/wsq_strobe_qual.sv
module wsq_strobe_qual #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PULSE_CYC = 3,
  parameter int unsigned PROTECT_CYC = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic              prst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  import wsq_pkg::*;
  localparam int unsigned BUS_W = ADDR_W + DATA_W;

  pin_ctrl_t         ctrl_raw, ctrl_s;
  logic [BUS_W-1:0]  bus_s;
  logic              win_s, oe_n_s, blocked;

  assign ctrl_raw = '{prst_n: prst_ni, oe_n: oe_ni, we_n: we_ni, cs_n: cs_ni};

  wsq_sync #(.W($bits(pin_ctrl_t)), .STAGES(SYNC_STAGES), .RST_VAL(CTRL_IDLE)) u_sync_ctrl (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ctrl_raw),
    .q_o   (ctrl_s)
  );

  wsq_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({addr_i, data_i}),
    .q_o   (bus_s)
  );

  assign win_s  = ~ctrl_s.cs_n & ~ctrl_s.we_n;
  assign oe_n_s = ctrl_s.oe_n;

  wsq_protect #(.PROTECT_CYC(PROTECT_CYC)) u_protect (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .prst_n_i (ctrl_s.prst_n),
    .blocked_o(blocked)
  );

  wsq_window #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE_CYC(MIN_PULSE_CYC)) u_window (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .win_i     (win_s),
    .oe_hi_i   (oe_n_s),
    .blocked_i (blocked),
    .addr_i    (bus_s[BUS_W-1:DATA_W]),
    .data_i    (bus_s[DATA_W-1:0]),
    .wr_valid_o(wr_valid_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o)
  );
endmodule

// File: rtl/wsq_checker.sv
module wsq_checker #(
  parameter int unsigned ADDR_W = 17,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MIN_PULSE_CYC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              win_s,
  input logic              oe_n_s,
  input logic              blocked,
  input logic              wr_valid_o,
  input logic [ADDR_W-1:0] wr_addr_o,
  input logic [DATA_W-1:0] wr_data_o
);
  localparam int unsigned RUN_W = $clog2(MIN_PULSE_CYC + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(MIN_PULSE_CYC);

  logic [RUN_W-1:0] run_q, last_run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      last_run_q <= '0;
    end else if (win_s) begin
      if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
    end else begin
      if (run_q != '0) last_run_q <= run_q;
      run_q <= '0;
    end
  end

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_valid_o |-> ($stable(wr_addr_o) && $stable(wr_data_o))); // R8
  AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (last_run_q >= RUN_MAX)); // R5
  AST_OE_INHIBIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(oe_n_s, 2) == 1'b0); // R4
  AST_NOT_BLOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(blocked, 2)); // R6
  AST_WINDOW_CLOSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> $past(win_s, 2) && !$past(win_s)); // R1
endmodule

bind wsq_strobe_qual wsq_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_PULSE_CYC(MIN_PULSE_CYC)
) u_wsq_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .win_s     (win_s),
  .oe_n_s    (oe_n_s),
  .blocked   (blocked),
  .wr_valid_o(wr_valid_o),
  .wr_addr_o (wr_addr_o),
  .wr_data_o (wr_data_o)
);

// File: tb/tb_wsq_strobe_qual.sv
`timescale 1ns/1ps
module tb_wsq_strobe_qual;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;
  localparam int MIN_CYC = 3;
  localparam int PROT_CYC = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, prst_n = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] data = '0;
  logic wr_valid;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  int checks = 0, errors = 0;
  int pulses = 0, back_to_back = 0;
  logic prev_valid = 1'b0;
  logic [ADDR_W-1:0] cap_addr = '0;
  logic [DATA_W-1:0] cap_data = '0;

  always #10 clk = ~clk;

  wsq_strobe_qual #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(2),
                    .MIN_PULSE_CYC(MIN_CYC), .PROTECT_CYC(PROT_CYC)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .we_ni(we_n), .oe_ni(oe_n),
    .prst_ni(prst_n), .addr_i(addr), .data_i(data),
    .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
  );

  always @(posedge clk) begin
    if (wr_valid) begin
      pulses   <= pulses + 1;
      cap_addr <= wr_addr;
      cap_data <= wr_data;
      if (prev_valid) back_to_back <= back_to_back + 1;
    end
    prev_valid <= wr_valid;
  end

  task automatic check(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // window of len cycles; address junk after open, data valid only in last cycle
  task automatic overlap(input bit cs_falls_first, input bit cs_rises_first,
                         input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d, input int len);
    @(negedge clk);
    addr = ~a; data = ~d;
    if (cs_falls_first) cs_n = 1'b0; else we_n = 1'b0;
    cyc(2);
    addr = a;
    if (len == 1) data = d;
    if (cs_falls_first) we_n = 1'b0; else cs_n = 1'b0;
    if (len > 1) begin
      cyc(1);
      addr = a ^ 17'h0_1234;
      cyc(len - 2);
      data = d;
    end
    cyc(1);
    data = d ^ 8'hFF;
    if (cs_rises_first) cs_n = 1'b1; else we_n = 1'b1;
    cyc(1);
    cs_n = 1'b1; we_n = 1'b1;
    cyc(6);
  endtask

  task automatic t_reset();
    check("R9 valid", wr_valid, 0);
    check("R9 addr", wr_addr, 0);
    check("R9 data", wr_data, 0);
  endtask

  task automatic t_orderings();
    int p0 = pulses;
    overlap(1'b1, 1'b0, 17'h1_5555, 8'hA5, 5);
    check("R1 we-controlled pulse count", pulses - p0, 1);
    check("R2 later fall latches addr", cap_addr, 17'h1_5555);
    check("R3 earlier rise latches data", cap_data, 8'hA5);
    overlap(1'b0, 1'b1, 17'h0_2AAA, 8'h3C, 4);
    check("R1 cs-controlled pulse count", pulses - p0, 2);
    check("R2 cs-controlled addr", cap_addr, 17'h0_2AAA);
    check("R3 cs-controlled data", cap_data, 8'h3C);
    check("R8 held addr", wr_addr, 17'h0_2AAA);
  endtask

  task automatic t_width();
    int p0 = pulses;
    overlap(1'b1, 1'b1, 17'h0_0011, 8'h11, MIN_CYC - 1);
    check("R5 short window rejected", pulses - p0, 0);
    check("R5 outputs unchanged", wr_addr, 17'h0_2AAA);
    overlap(1'b0, 1'b0, 17'h0_0022, 8'h22, MIN_CYC);
    check("R5 minimum window accepted", pulses - p0, 1);
    check("R5 minimum window data", cap_data, 8'h22);
  endtask

  task automatic t_oe();
    int p0 = pulses;
    oe_n = 1'b0;
    overlap(1'b1, 1'b0, 17'h1_0F0F, 8'h77, 5);
    oe_n = 1'b1;
    check("R4 oe low whole window", pulses - p0, 0);
    fork
      overlap(1'b1, 1'b0, 17'h1_0E0E, 8'h66, 7);
      begin cyc(5); oe_n = 1'b0; cyc(1); oe_n = 1'b1; end
    join
    check("R4 oe dip inside window", pulses - p0, 0);
    check("R4 addr kept", wr_addr, 17'h0_0022);
    check("R4 data kept", wr_data, 8'h22);
  endtask

  task automatic t_prst();
    int p0 = pulses;
    prst_n = 1'b0;
    cyc(3);
    overlap(1'b1, 1'b0, 17'h0_4444, 8'h44, 5);
    check("R6 pin reset low blocks", pulses - p0, 0);
    prst_n = 1'b1;
    overlap(1'b1, 1'b0, 17'h0_5555, 8'h55, 4);
    check("R7 write inside protect interval", pulses - p0, 0);
    cyc(PROT_CYC + 4);
    overlap(1'b0, 1'b0, 17'h0_6666, 8'h66, 4);
    check("R7 write after protect interval", pulses - p0, 1);
    check("R7 addr after protect", cap_addr, 17'h0_6666);
  endtask

  initial begin
    cyc(3);
    t_reset();
    rst_n = 1'b1;
    cyc(PROT_CYC + 8);
    check("R1 no event while idle", pulses, 0);
    t_orderings();
    t_width();
    t_oe();
    t_prst();
    check("R8 single-cycle pulses", back_to_back, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule